// File: doc/BRIEF.md
# DAC Clamp and Sleep Control

This block decides, for two bipolar DAC pairs and four auxiliary DACs, whether each output runs normally or is held at a clamp level, and which clamp level applies. Channels can be clamped in three ways. Software sets bits in a clamp register. Either of two sleep pins forces the channels that its configuration word masks. A supply-fault flag forces both bipolar pairs onto the negative rail. The block also drives the power-amplifier enable from the sleep pins.

When a channel leaves clamp, the block sends a one-cycle reload strobe for that channel. The data path uses it to apply the active code at once, whatever its update mode. Clamping never touches the data registers, which live outside this block.

A sleep pin can be set to "snooze". In that mode the clamp it forced stays in place after the pin falls, until the host clears the clamp bit. The sleep pins and the fault flag pass through two-flop synchronizers. A register write reaches the outputs two clock edges later.

Top module: `dac_clamp_sleep`

## Requirements
- R1: Clamp register (select 0) bit map: bit 0 is bipolar pair A, bit 1 is bipolar pair B, bits 2 to 5 are auxiliary DACs 1 to 4. Writing 1 clamps the channel and writing 0 releases it. `clampReg` reads back the register.
- R2: Sleep configuration words are at select 1 (pin 0) and select 2 (pin 1). Bits 5:0 are a channel mask in the R1 bit order, bit 6 is snooze and bit 7 is PA-disable. While a pin is high, its masked channels are clamped and unmasked channels are unaffected.
- R3: While a channel is forced by a sleep pin, host writes to its clamp bit are ignored. Writes to the other bits take effect.
- R4: With snooze 0, the pin going low releases the channels it forced, unless something else still clamps them.
- R5: With snooze 1, a forced channel also sets its clamp bit, which reads back 1. The channel stays clamped after the pin falls, until the host writes 0 to that bit.
- R6: The supply-fault flag clamps both bipolar pairs while it is high.
- R7: `clampSrc` holds 2 bits per channel, channel c at bits [2c+1:2c]. 00 means not clamped, 01 means scaled reference (bipolar), 10 means negative rail (bipolar while the fault is high, which takes priority), and 11 means ground (auxiliary always).
- R8: `reloadPulse[c]` is high for exactly one cycle, in the cycle that `clampActive[c]` falls. It is never high when a clamp is entered.
- R9: `paEnable` is low while any sleep pin is high and its PA-disable bit is set, and high otherwise.
- R10: After reset no channel is clamped, all sources are 00, `paEnable` is 1, and the clamp register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 clamp, 1 sleep config pin 0, 2 sleep config pin 1 |
| regData | input | 8 | Write data |
| sleepPin | input | 2 | Asynchronous sleep pins |
| supplyFault | input | 1 | Asynchronous supply-out-of-range flag |
| clampActive | output | 6 | Per-channel clamp state |
| clampSrc | output | 12 | Per-channel clamp source code |
| paEnable | output | 1 | Power-amplifier enable |
| reloadPulse | output | 6 | Per-channel release strobe to the data path |
| clampReg | output | 6 | Clamp register readback |

## Verification
The assertions assume that the sleep pins and the fault flag are only seen after synchronization. They also assume that `regSel` never holds a value above 2 while `regWr` is high. The stimulus changes the asynchronous inputs and the write controls only on the falling clock edge. It uses only the three defined selects. After each change it waits enough cycles for the synchronizer and the output register before sampling. Reload strobes are counted on every rising edge, so a missing pulse or a repeated pulse both show up in the counts.

// File: rtl/dac_clamp_pkg.sv
package dac_clamp_pkg;
  parameter int NUM_PAIR  = 2;
  parameter int NUM_AUX   = 4;
  parameter int NUM_SLEEP = 2;
  localparam int NUM_CH   = NUM_PAIR + NUM_AUX;
  localparam int CFG_W    = NUM_CH + 2;
  localparam int SNOOZE_BIT = NUM_CH;
  localparam int PADIS_BIT  = NUM_CH + 1;
  localparam int SEL_W    = $clog2(NUM_SLEEP + 1);
  localparam int SRC_W    = 2;

  localparam logic [SRC_W-1:0] SRC_NONE = 2'b00;
  localparam logic [SRC_W-1:0] SRC_REF  = 2'b01;
  localparam logic [SRC_W-1:0] SRC_NEG  = 2'b10;
  localparam logic [SRC_W-1:0] SRC_GND  = 2'b11;

  typedef struct packed {
    logic [NUM_CH-1:0] clampNext;
    logic              altRail;
    logic              paOff;
  } clampStrobe_t;
endpackage

// File: rtl/dac_clamp_sync.sv
module dac_clamp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/dac_clamp_ctrl.sv
module dac_clamp_ctrl
  import dac_clamp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [SEL_W-1:0]     regSel,
  input  logic [CFG_W-1:0]     regData,
  input  logic [NUM_SLEEP-1:0] sleepS,
  input  logic                 faultS,
  output clampStrobe_t         strobe,
  output logic [NUM_CH-1:0]    clampReg
);
  localparam logic [NUM_CH-1:0] PAIR_MASK = NUM_CH'((1 << NUM_PAIR) - 1);

  logic [NUM_CH-1:0]    sleepMask [NUM_SLEEP];
  logic [NUM_SLEEP-1:0] snoozeEn;
  logic [NUM_SLEEP-1:0] paDis;
  logic [NUM_CH-1:0]    forceMask;
  logic [NUM_CH-1:0]    snoozeSet;
  logic                 wrClamp;

  assign wrClamp = regWr && (regSel == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_SLEEP; p++) sleepMask[p] <= '0;
      snoozeEn <= '0;
      paDis    <= '0;
    end else begin
      for (int p = 0; p < NUM_SLEEP; p++) begin
        if (regWr && (regSel == SEL_W'(p + 1))) begin
          sleepMask[p] <= regData[NUM_CH-1:0];
          snoozeEn[p]  <= regData[SNOOZE_BIT];
          paDis[p]     <= regData[PADIS_BIT];
        end
      end
    end
  end

  always_comb begin
    forceMask = '0;
    snoozeSet = '0;
    for (int p = 0; p < NUM_SLEEP; p++) begin
      if (sleepS[p]) begin
        forceMask = forceMask | sleepMask[p];
        if (snoozeEn[p]) snoozeSet = snoozeSet | sleepMask[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clampReg <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (snoozeSet[c])                  clampReg[c] <= 1'b1;
        else if (wrClamp && !forceMask[c]) clampReg[c] <= regData[c];
      end
    end
  end

  always_comb begin
    strobe.clampNext = clampReg | forceMask | (faultS ? PAIR_MASK : '0);
    strobe.altRail   = faultS;
    strobe.paOff     = |(sleepS & paDis);
  end

  // R3: a forced channel's clamp bit does not follow a host write
  assert_forced_write_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrClamp |=> (((clampReg ^ $past(clampReg)) & $past(forceMask & ~snoozeSet)) == '0));

  // R5: snooze forcing leaves the clamp bit set
  assert_snooze_sets_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|snoozeSet) |=> ((clampReg & $past(snoozeSet)) == $past(snoozeSet)));
endmodule

// File: rtl/dac_clamp_dp.sv
module dac_clamp_dp
  import dac_clamp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  clampStrobe_t             strobe,
  output logic [NUM_CH-1:0]        clampActive,
  output logic [NUM_CH*SRC_W-1:0]  clampSrc,
  output logic                     paEnable,
  output logic [NUM_CH-1:0]        reloadPulse
);
  logic [NUM_CH*SRC_W-1:0] srcNext;

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    if (c < NUM_PAIR) begin : gPair
      assign srcNext[c*SRC_W +: SRC_W] = !strobe.clampNext[c] ? SRC_NONE :
                                         (strobe.altRail ? SRC_NEG : SRC_REF);
    end else begin : gAux
      assign srcNext[c*SRC_W +: SRC_W] = strobe.clampNext[c] ? SRC_GND : SRC_NONE;

      // R7: auxiliary channels only ever report ground
      assert_aux_ground_R7: assert property (@(posedge clk) disable iff (!rstN)
        clampActive[c] |-> (clampSrc[c*SRC_W +: SRC_W] == SRC_GND));
    end

    // R7: a source code is reported exactly when the channel is clamped
    assert_src_matches_state_R7: assert property (@(posedge clk) disable iff (!rstN)
      (clampSrc[c*SRC_W +: SRC_W] != SRC_NONE) == clampActive[c]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clampActive <= '0;
      clampSrc    <= '0;
      paEnable    <= 1'b1;
      reloadPulse <= '0;
    end else begin
      clampActive <= strobe.clampNext;
      clampSrc    <= srcNext;
      paEnable    <= !strobe.paOff;
      reloadPulse <= clampActive & ~strobe.clampNext;
    end
  end

  // R8: reload only on a release edge
  assert_reload_on_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|reloadPulse) |-> (((reloadPulse & clampActive) == '0) &&
                        ((reloadPulse & ~$past(clampActive)) == '0)));

  // R6: the fault puts both pairs on the negative rail
  assert_fault_neg_rail_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.altRail |=> ((clampActive[NUM_PAIR-1:0] == '1) &&
                        (clampSrc[SRC_W-1:0] == SRC_NEG)));

  // R9: PA-disable request drops the enable
  assert_pa_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.paOff |=> !paEnable);
endmodule

// File: rtl/dac_clamp_sleep.sv
module dac_clamp_sleep
  import dac_clamp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWr,
  input  logic [SEL_W-1:0]        regSel,
  input  logic [CFG_W-1:0]        regData,
  input  logic [NUM_SLEEP-1:0]    sleepPin,
  input  logic                    supplyFault,
  output logic [NUM_CH-1:0]       clampActive,
  output logic [NUM_CH*SRC_W-1:0] clampSrc,
  output logic                    paEnable,
  output logic [NUM_CH-1:0]       reloadPulse,
  output logic [NUM_CH-1:0]       clampReg
);
  logic [NUM_SLEEP:0] syncIn;
  logic [NUM_SLEEP:0] syncOut;
  clampStrobe_t       strobe;

  assign syncIn = {supplyFault, sleepPin};

  dac_clamp_sync #(.WIDTH(NUM_SLEEP + 1), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn(syncIn), .syncOut(syncOut)
  );

  dac_clamp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regData(regData),
    .sleepS(syncOut[NUM_SLEEP-1:0]), .faultS(syncOut[NUM_SLEEP]),
    .strobe(strobe), .clampReg(clampReg)
  );

  dac_clamp_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clampActive(clampActive),
    .clampSrc(clampSrc), .paEnable(paEnable), .reloadPulse(reloadPulse)
  );
endmodule

// File: tb/test_dac_clamp_sleep.sv
module test_dac_clamp_sleep;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = '0;
  logic [7:0]  regData = '0;
  logic [1:0]  sleepPin = '0;
  logic        supplyFault = 1'b0;
  logic [5:0]  clampActive;
  logic [11:0] clampSrc;
  logic        paEnable;
  logic [5:0]  reloadPulse;
  logic [5:0]  clampReg;

  int checkCnt = 0;
  int failCnt = 0;
  int reloadCnt [6];
  logic cntClr = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_clamp_sleep i_dac_clamp_sleep (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regData(regData),
    .sleepPin(sleepPin), .supplyFault(supplyFault), .clampActive(clampActive),
    .clampSrc(clampSrc), .paEnable(paEnable), .reloadPulse(reloadPulse),
    .clampReg(clampReg)
  );

  always @(posedge clk) begin
    for (int c = 0; c < 6; c++) begin
      if (cntClr) reloadCnt[c] = 0;
      else if (reloadPulse[c]) reloadCnt[c] = reloadCnt[c] + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regData = data;
    @(negedge clk);
    regWr = 1'b0;
    waitCyc(3);
  endtask

  task automatic clearCounts();
    @(negedge clk); cntClr = 1'b1;
    @(negedge clk); cntClr = 1'b0;
  endtask

  task automatic checkReloads(input string req, input logic [5:0] expMask);
    for (int c = 0; c < 6; c++) check(req, reloadCnt[c], expMask[c] ? 1 : 0);
  endtask

  task automatic testReset();
    check("R10 active", clampActive, 0);
    check("R10 src", clampSrc, 0);
    check("R10 pa", paEnable, 1);
    check("R10 reg", clampReg, 0);
  endtask

  task automatic testSoftwareClamp();
    clearCounts();
    writeReg(2'd0, 8'b0010_0101);
    check("R1 active", clampActive, 6'b100101);
    check("R1 readback", clampReg, 6'b100101);
    check("R7 src", clampSrc, 12'b11_00_00_11_00_01);
    checkReloads("R8 no pulse on entry", 6'b000000);
    writeReg(2'd0, 8'h00);
    check("R1 release", clampActive, 0);
    check("R7 src none", clampSrc, 0);
    checkReloads("R8 pulse on release", 6'b100101);
  endtask

  task automatic testSleepNoSnooze();
    writeReg(2'd1, 8'b1000_0110);
    clearCounts();
    sleepPin[0] = 1'b1;
    waitCyc(5);
    check("R2 forced", clampActive, 6'b000110);
    check("R9 pa low", paEnable, 0);
    writeReg(2'd0, 8'b0000_1110);
    check("R3 forced bits ignored", clampReg, 6'b001000);
    check("R3 other bit taken", clampActive, 6'b001110);
    sleepPin[0] = 1'b0;
    waitCyc(5);
    check("R4 released", clampActive, 6'b001000);
    check("R9 pa high", paEnable, 1);
    checkReloads("R8 sleep release", 6'b000110);
    writeReg(2'd0, 8'h00);
    writeReg(2'd1, 8'h00);
    check("R1 all clear", clampActive, 0);
  endtask

  task automatic testSnooze();
    writeReg(2'd2, 8'b0111_0001);
    sleepPin[1] = 1'b1;
    waitCyc(5);
    check("R2 forced pin1", clampActive, 6'b110001);
    check("R5 bit set", clampReg, 6'b110001);
    check("R9 pa stays", paEnable, 1);
    writeReg(2'd0, 8'h00);
    check("R3 write ignored", clampReg, 6'b110001);
    sleepPin[1] = 1'b0;
    waitCyc(5);
    clearCounts();
    check("R5 held after pin low", clampActive, 6'b110001);
    writeReg(2'd0, 8'h00);
    check("R5 released by write", clampActive, 0);
    check("R5 reg clear", clampReg, 0);
    checkReloads("R8 snooze release", 6'b110001);
    writeReg(2'd2, 8'h00);
  endtask

  task automatic testFault();
    writeReg(2'd0, 8'b0001_0001);
    supplyFault = 1'b1;
    waitCyc(5);
    check("R6 pairs clamped", clampActive, 6'b010011);
    check("R7 fault priority", clampSrc, 12'b00_11_00_00_10_10);
    supplyFault = 1'b0;
    waitCyc(5);
    check("R6 fault gone", clampActive, 6'b010001);
    check("R7 ref back", clampSrc, 12'b00_11_00_00_00_01);
    writeReg(2'd0, 8'h00);
    check("R1 cleared", clampActive, 0);
  endtask

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    waitCyc(3);
    testReset();
    rstN = 1'b1;
    waitCyc(2);
    testSoftwareClamp();
    testSleepNoSnooze();
    testSnooze();
    testFault();
    done = 1'b1;
    finishTest();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishTest();
    end
  end
endmodule